// File: doc/BRIEF.md
# Partial-Sum Tree Reduction Controller

This block keeps a bank of partial sums in registers and folds a chosen number of them into a single total, halving the number of live entries on every clock. A host fills the bank through a one-word write port, then pulses `start` together with the number of entries to combine. In each round, every entry below the new dividing line takes in its partner from above that line. When the live count is odd, entry 0 also takes in the last live entry, so counts that are not a power of two need no padding.

A round reads only values from before the round, and all of its results are written together on one clock edge. Reduction of `c` entries therefore takes floor(log2 c) rounds. One more cycle follows, in which the total is captured and `done` pulses. Afterwards entry 0 of the bank holds the total, so a later reduction can build on it.

Top module: `psr_tree_reducer`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `total` is 0.
- R2: A write with `wr_en` high while `busy` is low stores `wr_data` at index `wr_idx` (index 0 is the first entry). A write while `busy` is high changes no entry.
- R3: A `start` pulse while idle begins a reduction of the first `start_count` entries. A `start_count` of 0, or one above NUM_SUMS, selects all NUM_SUMS entries.
- R4: When `done` pulses, `total` equals the sum of entries 0 to c-1 as they stood at start, and entry 0 of the bank then holds that same total.
- R5: `done` rises exactly floor(log2 c)+1 clock edges after the edge that samples `start`. It lasts one cycle, `busy` is low while it is high, and the live count halves on every busy cycle until it reaches 1.
- R6: Sums wrap modulo 2^DATA_W and raise no flag.
- R7: A `start` pulse while `busy` is high is ignored: the running reduction keeps its count, result and timing, and no extra `done` follows.
- R8: `total` holds its value in every cycle except the one in which `done` is high.
- R9: Entries at index c and above do not contribute to the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the entry bank |
| wr_idx | input | IDX_W | Entry index to write |
| wr_data | input | DATA_W | Value to store |
| start | input | 1 | One-cycle request to begin a reduction |
| start_count | input | CNT_W | Number of entries to combine (0 means all) |
| busy | output | 1 | High while rounds are in progress |
| done | output | 1 | One-cycle pulse when the total is valid |
| total | output | DATA_W | Result of the latest reduction |

## Verification
A wrong partner index, or a missed odd-count fold into entry 0, shows up as a wrong `total` at the very next `done`. It is caught with count values of 1, 2, 3, 7, 64 and 100, and with data chosen so that every entry has its own weight. A live count that is corrupted or never halved moves `done` off its exact expected edge. Errors in write gating while busy appear one reduction later: a single-entry run then returns something other than the prior total from entry 0.

// File: rtl/psr_pkg.sv
`timescale 1ns/1ps
package psr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } psr_state_e;
endpackage

// File: rtl/psr_reset_sync.sv
`timescale 1ns/1ps
module psr_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/psr_count_ctrl.sv
`timescale 1ns/1ps
module psr_count_ctrl #(
  parameter int N     = 100,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_cnt,
  output logic             busy,
  output logic [CNT_W-1:0] cnt,
  output logic             round_en,
  output logic             finish,
  output logic             done
);
  import psr_pkg::*;

  localparam logic [CNT_W-1:0] N_C   = CNT_W'(N);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  psr_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] eff_cnt;

  // Out-of-range or zero request selects the full bank
  always_comb begin
    if ((start_cnt == '0) || (start_cnt > N_C)) eff_cnt = N_C;
    else                                        eff_cnt = start_cnt;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_RUN;
          cnt_d = eff_cnt;
        end
      end
      ST_RUN: begin
        if (cnt_q > ONE_C) begin
          cnt_d = cnt_q >> 1;
        end else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign busy     = (st_q == ST_RUN);
  assign cnt      = cnt_q;
  assign round_en = busy && (cnt_q > ONE_C);
  assign finish   = busy && (cnt_q == ONE_C);
  assign done     = done_q;
endmodule

// File: rtl/psr_round_datapath.sv
`timescale 1ns/1ps
module psr_round_datapath #(
  parameter int N     = 100,
  parameter int W     = 32,
  parameter int CNT_W = 7,
  parameter int IDX_W = 7
) (
  input  logic [N-1:0][W-1:0] cur,
  input  logic [CNT_W-1:0]    cnt,
  output logic [N-1:0][W-1:0] nxt
);
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] tail_pos;
  logic [IDX_W-1:0] tail_idx;
  logic [W-1:0]     tail_val;

  assign half     = cnt >> 1;
  assign tail_pos = cnt - CNT_W'(1);
  assign tail_idx = tail_pos[IDX_W-1:0];
  // Leftover entry is folded into entry 0 only for an odd live count
  assign tail_val = cnt[0] ? cur[tail_idx] : '0;

  for (genvar g = 0; g < N; g++) begin : g_lane
    localparam logic [CNT_W-1:0] GI = CNT_W'(g);
    logic [CNT_W-1:0] pair_pos;
    logic [IDX_W-1:0] pair_idx;
    logic             active;
    logic [W-1:0]     pair_sum;

    assign pair_pos = GI + half;
    assign pair_idx = pair_pos[IDX_W-1:0];
    assign active   = (GI < half);

    if (g == 0) begin : g_head
      assign pair_sum = cur[g] + cur[pair_idx] + tail_val;
    end else begin : g_body
      assign pair_sum = cur[g] + cur[pair_idx];
    end

    assign nxt[g] = active ? pair_sum : cur[g];
  end
endmodule

// File: rtl/psr_tree_reducer.sv
`timescale 1ns/1ps
module psr_tree_reducer #(
  parameter int NUM_SUMS = 100,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = $clog2(NUM_SUMS + 1),
  parameter int IDX_W    = (NUM_SUMS > 1) ? $clog2(NUM_SUMS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_count,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] total
);
  localparam int IDX_CMP_W = IDX_W + 1;
  localparam logic [IDX_CMP_W-1:0] N_IDX = IDX_CMP_W'(NUM_SUMS);

  logic                          rst_sync_n;
  logic [CNT_W-1:0]              cnt_q;
  logic                          round_en;
  logic                          finish;
  logic [NUM_SUMS-1:0][DATA_W-1:0] bank_q, bank_d, round_nxt;
  logic                          bank_we;
  logic                          wr_ok;
  logic [DATA_W-1:0]             total_q;

  psr_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psr_count_ctrl #(
    .N     (NUM_SUMS),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .start_cnt (start_count),
    .busy      (busy),
    .cnt       (cnt_q),
    .round_en  (round_en),
    .finish    (finish),
    .done      (done)
  );

  psr_round_datapath #(
    .N     (NUM_SUMS),
    .W     (DATA_W),
    .CNT_W (CNT_W),
    .IDX_W (IDX_W)
  ) u_dp (
    .cur (bank_q),
    .cnt (cnt_q),
    .nxt (round_nxt)
  );

  assign wr_ok   = wr_en && !busy && ({1'b0, wr_idx} < N_IDX);
  assign bank_we = round_en || wr_ok;

  always_comb begin
    bank_d = bank_q;
    if (round_en) begin
      bank_d = round_nxt;
    end else if (wr_ok) begin
      bank_d[wr_idx] = wr_data;
    end
  end

  // Storage bank: data only, no reset, written under an explicit enable
  always_ff @(posedge clk) begin
    if (bank_we) begin
      bank_q <= bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      total_q <= '0;
    end else if (finish) begin
      total_q <= bank_q[0];
    end
  end

  assign total = total_q;
endmodule

// File: rtl/psr_checks.sv
`timescale 1ns/1ps
module psr_checks #(
  parameter int N     = 100,
  parameter int W     = 32,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] cnt,
  input logic [W-1:0]     total
);
  localparam logic [CNT_W-1:0] N_C   = CNT_W'(N);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  p_cnt_bounds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((cnt >= ONE_C) && (cnt <= N_C)));

  p_halving_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cnt > ONE_C)) |=> (busy && (cnt == ($past(cnt) >> 1))));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy) && ($past(cnt) == ONE_C)));

  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt <= $past(cnt)));

  p_total_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(total));
endmodule

bind psr_tree_reducer psr_checks #(
  .N     (NUM_SUMS),
  .W     (DATA_W),
  .CNT_W (CNT_W)
) u_psr_checks (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .start (start),
  .busy  (busy),
  .done  (done),
  .cnt   (cnt_q),
  .total (total)
);

// File: tb/test_psr_tree_reducer.sv
`timescale 1ns/1ps
module test_psr_tree_reducer;
  localparam int N  = 100;
  localparam int W  = 32;
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [W-1:0]  wr_data;
  logic          start;
  logic [CW-1:0] start_count;
  logic          busy;
  logic          done;
  logic [W-1:0]  total;

  psr_tree_reducer #(.NUM_SUMS(N), .DATA_W(W)) i_psr_tree_reducer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .start(start), .start_count(start_count),
    .busy(busy), .done(done), .total(total)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int           n_checks = 0;
  int           n_fail   = 0;
  int           cyc      = 0;
  logic [W-1:0] model [N];
  logic [W-1:0] exp_tot_q [$];
  int           exp_lat_q [$];
  int           start_at_q [$];
  string        tag_q [$];
  logic [W-1:0] last_total = '0;
  bit           prev_done  = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lat_for(input int c);
    int l = 0;
    int k = c;
    while (k > 1) begin
      k = k / 2;
      l++;
    end
    return l + 1;
  endfunction

  // Monitor: pops expected items as results come out
  always @(posedge clk) begin
    #5;
    if (done) begin
      if (exp_tot_q.size() == 0) begin
        check(1'b0, "R7", "unexpected done", 1, 0);
      end else begin
        logic [W-1:0] et;
        int el, sa;
        string tg;
        et = exp_tot_q.pop_front();
        el = exp_lat_q.pop_front();
        sa = start_at_q.pop_front();
        tg = tag_q.pop_front();
        check(total == et, tg, "total", total, et);
        check((cyc - sa) == el, "R5", "done latency", W'(cyc - sa), W'(el));
        check(!busy, "R5", "busy low at done", W'(busy), 0);
        last_total = total;
      end
      if (prev_done) check(1'b0, "R5", "done wider than one cycle", 1, 0);
    end
    prev_done = done;
  end

  task automatic write_word(input int idx, input logic [W-1:0] v);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = IW'(idx);
    wr_data = v;
    model[idx] = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill(input int k);
    for (int i = 0; i < N; i++) begin
      write_word(i, W'((i + 1) * (k * 977 + 13)) ^ W'(k << 20));
    end
  endtask

  task automatic start_run(input int c, input string tag, input bit wait_done);
    int eff;
    logic [W-1:0] s;
    eff = ((c == 0) || (c > N)) ? N : c;
    s = '0;
    for (int i = 0; i < eff; i++) s = s + model[i];
    @(negedge clk);
    start       = 1'b1;
    start_count = CW'(c);
    exp_tot_q.push_back(s);
    exp_lat_q.push_back(lat_for(eff));
    start_at_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    if (wait_done) begin
      wait (exp_tot_q.size() == 0);
      @(negedge clk);
      model[0] = last_total;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    start = 1'b0; start_count = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy after reset", W'(busy), 0);
    check(done == 1'b0, "R1", "done after reset", W'(done), 0);
    check(total == '0,  "R1", "total after reset", total, 0);

    // R4 main function over several counts and patterns
    fill(1); start_run(1, "R4", 1'b1);
    fill(2); start_run(2, "R4", 1'b1);
    fill(3); start_run(3, "R4", 1'b1);
    // R9: entries 7..99 hold nonzero data that must not count
    fill(4); start_run(7, "R9", 1'b1);
    fill(5); start_run(64, "R4", 1'b1);
    fill(6); start_run(100, "R4", 1'b1);
    // R4: entry 0 keeps the total, a one-entry run returns it
    start_run(1, "R4", 1'b1);

    // R3 clamping of count
    fill(7); start_run(0, "R3", 1'b1);
    fill(8); start_run(120, "R3", 1'b1);

    // R6 wraparound
    for (int i = 0; i < N; i++) write_word(i, 32'hFFFF_FFF0 + W'(i));
    start_run(100, "R6", 1'b1);

    // R8 total held while idle and while busy
    repeat (6) @(negedge clk);
    check(total == last_total, "R8", "total held idle", total, last_total);
    fill(9);
    start_run(5, "R7", 1'b0);
    check(total == last_total, "R8", "total held busy", total, last_total);
    // R7 start while busy is ignored
    @(negedge clk);
    start = 1'b1; start_count = CW'(100);
    @(negedge clk);
    start = 1'b0;
    wait (exp_tot_q.size() == 0);
    @(negedge clk);
    model[0] = last_total;
    repeat (8) @(negedge clk);

    // R2 write while busy has no effect on entry 0
    fill(10);
    start_run(100, "R4", 1'b0);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = '0; wr_data = 32'hDEAD_BEEF;
    @(negedge clk);
    wr_en = 1'b0;
    wait (exp_tot_q.size() == 0);
    @(negedge clk);
    model[0] = last_total;
    start_run(1, "R2", 1'b1);
    // R2 write while idle lands at its index
    write_word(0, 32'h1234_5678);
    start_run(1, "R2", 1'b1);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule